// File: doc/BRIEF.md
# Floating-Point to Integer Converter

The converter turns one IEEE-754 binary32 or binary64 value into a 32-bit or 64-bit integer. The integer can be signed or unsigned. Per conversion, the caller picks the source format, the target width, the signedness, and whether the value is rounded to nearest-even or truncated toward zero. Each accepted input yields an integer result plus two flags: invalid and inexact.

The exception cases follow fixed rules.

- **NaN input:** the result is all ones across the target width, and invalid is raised.
- **Unsigned target, negative nonzero input:** the sign is examined before any rounding takes place. The result is 0 and invalid is raised, even when the magnitude would have rounded to zero.
- **Value out of range:** the result saturates to the nearest limit of the target, and invalid is raised.

The block is a two-stage pipeline and accepts one conversion on every clock. The first stage decodes the operand and aligns the significand onto the integer grid, keeping guard and sticky bits. The second stage rounds the value, classifies the exceptions and registers the result.

Top module: `f2i_conv`

## Requirements
- R1: A conversion presented with `in_valid` high is returned two clock edges later with `out_valid` high. A new conversion may be presented on every cycle, and `out_valid` follows `in_valid` delayed by two cycles.
- R2: With `in_dbl`=1 the operand is `in_bits[63:0]` as binary64. With `in_dbl`=0 it is `in_bits[31:0]` as binary32, and `in_bits[63:32]` has no effect.
- R3: `tgt_64`=1 selects a 64-bit result and `tgt_64`=0 a 32-bit result. A 32-bit result sits in `out_result[31:0]` with `out_result[63:32]` zero. `tgt_signed`=1 selects two's-complement and `tgt_signed`=0 selects unsigned.
- R4: With `rnd_chop`=0 the value is rounded to the nearest integer, with ties going to the even integer (2.5→2, 3.5→4, 0.5→0, 2.75→3).
- R5: With `rnd_chop`=1 the fraction is discarded toward zero (3.5→3, -1.5→-1).
- R6: For an unsigned target, every negative nonzero input gives 0 with invalid set and inexact clear, in both rounding modes. This includes negative infinity and values of magnitude below one.
- R7: A NaN input gives all ones in the target width with invalid set. For a 32-bit target this is `0x00000000FFFFFFFF`; for a 64-bit target it is all 64 bits set.
- R8: For a signed target, a value whose rounded magnitude exceeds the range saturates and raises invalid. A too-large positive value or +infinity gives the most positive value, and a too-large negative value or -infinity gives the most negative value. The most negative value itself converts exactly with no flag.
- R9: For an unsigned target, a positive value whose rounded magnitude exceeds the range, or +infinity, gives all ones in the target width with invalid set. This includes a value that only overflows after rounding up.
- R10: Inexact is set exactly when discarded fraction bits are nonzero and invalid is not set. The two flags are never high together.
- R11: +0.0 and -0.0 convert to 0 with no flag for every target.
- R12: While reset is applied and after it, `out_valid`, `out_result` and both flags are zero until a conversion emerges. Both flags are zero whenever `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand presented this cycle |
| in_dbl | input | 1 | 1: binary64 source, 0: binary32 source in bits 31:0 |
| in_bits | input | 64 | Operand bit pattern |
| tgt_64 | input | 1 | 1: 64-bit result, 0: 32-bit result |
| tgt_signed | input | 1 | 1: signed target, 0: unsigned target |
| rnd_chop | input | 1 | 1: truncate toward zero, 0: round to nearest-even |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Integer result, 32-bit results zero-extended |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Inexact flag |

## Verification
The bench builds the converter with its default widths of 64 and 32 bits. These place every saturation boundary within reach of directed operands: 2^31, 2^32, 2^63 and 2^64 each sit exactly on or just past a limit. So does 2^32 minus one half, which only overflows when rounding carries. The binary32 source covers denormals and garbage in the upper word. The binary64 source covers magnitudes that need a left shift. A back-to-back stream mixes both formats and all four targets on consecutive cycles.

// File: rtl/f2i_pkg.sv
// Shared constants and the decoded-operand type for the float-to-integer
// converter. Both source formats are widened to the binary64 significand
// width so that one aligner serves them.
package f2i_pkg;
    localparam int SP_EXP_W = 8;
    localparam int SP_MAN_W = 23;
    localparam int DP_EXP_W = 11;
    localparam int DP_MAN_W = 52;
    localparam int IN_W     = DP_EXP_W + DP_MAN_W + 1;
    localparam int SP_W     = SP_EXP_W + SP_MAN_W + 1;
    localparam int SIG_W    = DP_MAN_W + 1;   // significand with hidden bit
    localparam int EXP_SW   = DP_EXP_W + 2;   // signed unbiased exponent

    typedef struct packed {
        logic                     sign;
        logic                     nan;
        logic                     inf;
        logic                     zero;
        logic signed [EXP_SW-1:0] exp;   // value = sig * 2^(exp - (SIG_W-1))
        logic [SIG_W-1:0]         sig;
    } f2i_unpacked_t;
endpackage

// File: rtl/f2i_unpack.sv
// Decodes one IEEE-754 operand of the given exponent and mantissa width into
// sign, class bits, unbiased exponent and a left-justified significand of
// SIG_W bits. Assumes MAN_W < SIG_W and EXP_W + 2 <= EXP_SW.
// Denormals get the minimum exponent and a zero hidden bit.
module f2i_unpack
    import f2i_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [EXP_W+MAN_W:0] bits,
    output f2i_unpacked_t        fields
);
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;

    logic [EXP_W-1:0] e_raw;
    logic [MAN_W-1:0] f_raw;

    assign e_raw = bits[EXP_W+MAN_W-1:MAN_W];
    assign f_raw = bits[MAN_W-1:0];

    // Classify the operand and place its significand at the top of SIG_W bits.
    always_comb begin
        fields                        = '0;
        fields.sign                   = bits[EXP_W+MAN_W];
        fields.nan                    = (&e_raw) && (|f_raw);
        fields.inf                    = (&e_raw) && !(|f_raw);
        fields.zero                   = !(|e_raw) && !(|f_raw);
        fields.exp                    = EXP_SW'((e_raw == '0) ? (1 - BIAS)
                                                              : (int'(e_raw) - BIAS));
        fields.sig[SIG_W-1]           = |e_raw;
        fields.sig[SIG_W-2 -: MAN_W]  = f_raw;
    end
endmodule

// File: rtl/f2i_align.sv
// Moves the binary point of a decoded significand to the integer boundary.
// Yields the integer magnitude, a guard bit (first discarded bit) and a
// sticky bit (OR of all later discarded bits). Flags 'huge' when the exponent
// alone puts the value at or beyond 2^WIDE_W. Assumes WIDE_W >= SIG_W.
module f2i_align
    import f2i_pkg::*;
#(
    parameter int WIDE_W = 64
) (
    input  logic signed [EXP_SW-1:0] fld_exp,
    input  logic [SIG_W-1:0]         fld_sig,
    output logic [WIDE_W-1:0]        mag,
    output logic                     guard,
    output logic                     sticky,
    output logic                     huge
);
    localparam int FRAC = SIG_W - 1;        // fraction bits below the hidden bit
    localparam int SPAN = SIG_W + 1;        // shift at which everything is sticky
    localparam int TW   = SIG_W + SPAN;

    int            e_i;
    int            sh;
    logic [TW-1:0] t;

    // Select left shift, right shift with guard/sticky, or out-of-range.
    always_comb begin
        e_i    = int'(fld_exp);
        sh     = 0;
        t      = '0;
        mag    = '0;
        guard  = 1'b0;
        sticky = 1'b0;
        huge   = 1'b0;
        if (e_i >= WIDE_W) begin
            huge = 1'b1;
        end else if (e_i >= FRAC) begin
            mag = WIDE_W'(fld_sig) << (e_i - FRAC);
        end else begin
            sh     = FRAC - e_i;
            if (sh > SPAN) sh = SPAN;
            t      = {fld_sig, SPAN'(0)} >> sh;
            mag    = WIDE_W'(t[TW-1:SPAN]);
            guard  = t[SPAN-1];
            sticky = |t[SPAN-2:0];
        end
    end
endmodule

// File: rtl/f2i_round.sv
// Rounds an aligned magnitude and applies the exception rules in priority
// order: NaN, then negative input to an unsigned target, then overflow, then
// zero, then the ordinary signed or unsigned result. Results narrower than
// WIDE_W are zero-extended. Assumes NARROW_W < WIDE_W.
module f2i_round #(
    parameter int WIDE_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic              sign,
    input  logic              nan,
    input  logic              inf,
    input  logic              zero,
    input  logic              huge,
    input  logic [WIDE_W-1:0] mag,
    input  logic              guard,
    input  logic              sticky,
    input  logic              tgt_64,
    input  logic              tgt_signed,
    input  logic              chop,
    output logic [WIDE_W-1:0] result,
    output logic              invalid,
    output logic              inexact
);
    logic              inc;
    logic [WIDE_W:0]   rnd;
    logic [WIDE_W:0]   u_max;
    logic [WIDE_W:0]   s_pos_max;
    logic [WIDE_W:0]   s_neg_mag;
    logic [WIDE_W:0]   limit;
    logic [WIDE_W-1:0] ones_res;
    logic [WIDE_W-1:0] neg_res;
    logic              over;

    // Nearest-even increment and the rounded magnitude with carry-out.
    assign inc = !chop && guard && (sticky || mag[0]);
    assign rnd = {1'b0, mag} + (WIDE_W+1)'(inc);

    // Range limits of the selected target width.
    assign u_max     = tgt_64 ? {1'b0, {WIDE_W{1'b1}}} : (WIDE_W+1)'({NARROW_W{1'b1}});
    assign s_pos_max = u_max >> 1;
    assign s_neg_mag = s_pos_max + (WIDE_W+1)'(1);
    assign ones_res  = u_max[WIDE_W-1:0];
    assign limit     = tgt_signed ? (sign ? s_neg_mag : s_pos_max) : u_max;
    assign over      = huge || inf || (rnd > limit);
    assign neg_res   = (~rnd[WIDE_W-1:0] + WIDE_W'(1)) & ones_res;

    // Priority selection of result and flags.
    always_comb begin
        result  = '0;
        invalid = 1'b0;
        inexact = 1'b0;
        if (nan) begin
            result  = ones_res;
            invalid = 1'b1;
        end else if (!tgt_signed && sign && !zero) begin
            invalid = 1'b1;
        end else if (over) begin
            invalid = 1'b1;
            if (!tgt_signed)  result = ones_res;
            else if (sign)    result = s_neg_mag[WIDE_W-1:0];
            else              result = s_pos_max[WIDE_W-1:0];
        end else if (!zero) begin
            result  = sign ? neg_res : rnd[WIDE_W-1:0];
            inexact = guard || sticky;
        end
    end
endmodule

// File: rtl/f2i_conv.sv
// Two-stage float-to-integer converter. Stage 1 decodes the binary32 or
// binary64 operand and aligns it onto the integer grid. Stage 2 rounds,
// resolves exceptions and registers the result. One conversion per cycle,
// no stall. Synchronous active-low reset clears the valid bits and outputs.
module f2i_conv
    import f2i_pkg::*;
#(
    parameter int WIDE_W   = 64,
    parameter int NARROW_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_dbl,
    input  logic [IN_W-1:0]   in_bits,
    input  logic              tgt_64,
    input  logic              tgt_signed,
    input  logic              rnd_chop,
    output logic              out_valid,
    output logic [WIDE_W-1:0] out_result,
    output logic              out_invalid,
    output logic              out_inexact
);
    localparam int N_FMT = 2;

    f2i_unpacked_t     fmt_f [N_FMT];
    f2i_unpacked_t     sel_f;
    logic [WIDE_W-1:0] al_mag;
    logic              al_guard, al_sticky, al_huge;

    logic              s1_valid, s1_sign, s1_nan, s1_inf, s1_zero, s1_huge;
    logic [WIDE_W-1:0] s1_mag;
    logic              s1_guard, s1_sticky, s1_t64, s1_sgn, s1_chop;

    logic [WIDE_W-1:0] rd_result;
    logic              rd_invalid, rd_inexact;

    // One decoder per source format: index 0 binary32, index 1 binary64.
    for (genvar g = 0; g < N_FMT; g++) begin : g_fmt
        if (g == 0) begin : g_sp
            f2i_unpack #(.EXP_W(SP_EXP_W), .MAN_W(SP_MAN_W)) u_unpack (
                .bits   (in_bits[SP_W-1:0]),
                .fields (fmt_f[g])
            );
        end else begin : g_dp
            f2i_unpack #(.EXP_W(DP_EXP_W), .MAN_W(DP_MAN_W)) u_unpack (
                .bits   (in_bits),
                .fields (fmt_f[g])
            );
        end
    end

    assign sel_f = in_dbl ? fmt_f[1] : fmt_f[0];

    f2i_align #(.WIDE_W(WIDE_W)) u_align (
        .fld_exp (sel_f.exp),
        .fld_sig (sel_f.sig),
        .mag     (al_mag),
        .guard   (al_guard),
        .sticky  (al_sticky),
        .huge    (al_huge)
    );

    // Stage 1 register: aligned operand and conversion controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_sign   <= 1'b0;
            s1_nan    <= 1'b0;
            s1_inf    <= 1'b0;
            s1_zero   <= 1'b0;
            s1_huge   <= 1'b0;
            s1_mag    <= '0;
            s1_guard  <= 1'b0;
            s1_sticky <= 1'b0;
            s1_t64    <= 1'b0;
            s1_sgn    <= 1'b0;
            s1_chop   <= 1'b0;
        end else begin
            s1_valid  <= in_valid;
            s1_sign   <= sel_f.sign;
            s1_nan    <= sel_f.nan;
            s1_inf    <= sel_f.inf;
            s1_zero   <= sel_f.zero;
            s1_huge   <= al_huge;
            s1_mag    <= al_mag;
            s1_guard  <= al_guard;
            s1_sticky <= al_sticky;
            s1_t64    <= tgt_64;
            s1_sgn    <= tgt_signed;
            s1_chop   <= rnd_chop;
        end
    end

    f2i_round #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_round (
        .sign       (s1_sign),
        .nan        (s1_nan),
        .inf        (s1_inf),
        .zero       (s1_zero),
        .huge       (s1_huge),
        .mag        (s1_mag),
        .guard      (s1_guard),
        .sticky     (s1_sticky),
        .tgt_64     (s1_t64),
        .tgt_signed (s1_sgn),
        .chop       (s1_chop),
        .result     (rd_result),
        .invalid    (rd_invalid),
        .inexact    (rd_inexact)
    );

    // Stage 2 register: final result, flags qualified by valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_result  <= '0;
            out_invalid <= 1'b0;
            out_inexact <= 1'b0;
        end else begin
            out_valid   <= s1_valid;
            out_result  <= s1_valid ? rd_result : '0;
            out_invalid <= s1_valid && rd_invalid;
            out_inexact <= s1_valid && rd_inexact;
        end
    end
endmodule

// File: rtl/f2i_conv_chk.sv
// Protocol and exception-rule checker for f2i_conv, attached by bind.
// It relates each output to the operand that entered two cycles earlier.
module f2i_conv_chk
    import f2i_pkg::*;
#(
    parameter int WIDE_W   = 64,
    parameter int NARROW_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_dbl,
    input logic [IN_W-1:0]   in_bits,
    input logic              tgt_64,
    input logic              tgt_signed,
    input logic              out_valid,
    input logic [WIDE_W-1:0] out_result,
    input logic              out_invalid,
    input logic              out_inexact
);
    logic in_neg;
    logic in_nan;

    assign in_neg = in_dbl ? in_bits[IN_W-1] : in_bits[SP_W-1];
    assign in_nan = in_dbl ? ((&in_bits[IN_W-2:DP_MAN_W]) && (|in_bits[DP_MAN_W-1:0]))
                           : ((&in_bits[SP_W-2:SP_MAN_W]) && (|in_bits[SP_MAN_W-1:0]));

    // R1: result valid two cycles after the operand.
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (out_valid == $past(in_valid, 2)));

    // R3: narrow results are zero-extended.
    p_narrow_zext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(tgt_64, 2)) |-> (out_result[WIDE_W-1:NARROW_W] == '0));

    // R6: a negative non-NaN input to an unsigned target yields 0, never inexact.
    p_unsigned_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(tgt_signed, 2) && $past(in_neg, 2) && !$past(in_nan, 2))
        |-> (out_result == '0 && !out_inexact));

    // R7: NaN yields all ones in at least the narrow field, with invalid.
    p_nan_ones_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_nan, 2)) |-> (out_invalid && (&out_result[NARROW_W-1:0])));

    // R10: invalid and inexact are mutually exclusive.
    p_flag_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !(out_invalid && out_inexact));

    // R12: flags are silent when no result is valid.
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_invalid && !out_inexact));
endmodule

bind f2i_conv f2i_conv_chk #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_dbl      (in_dbl),
    .in_bits     (in_bits),
    .tgt_64      (tgt_64),
    .tgt_signed  (tgt_signed),
    .out_valid   (out_valid),
    .out_result  (out_result),
    .out_invalid (out_invalid),
    .out_inexact (out_inexact)
);

// File: tb/f2i_conv_bench.sv
// Directed bench for f2i_conv: one task per scenario, each checking its own
// results against hand-derived expectations.
module f2i_conv_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_dbl = 1'b0;
    logic [63:0] in_bits = '0;
    logic        tgt_64 = 1'b0;
    logic        tgt_signed = 1'b0;
    logic        rnd_chop = 1'b0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_invalid;
    logic        out_inexact;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] LO32 = 64'h0000_0000_FFFF_FFFF;

    always #4 clk = ~clk;

    f2i_conv u_f2i_conv (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dbl(in_dbl),
        .in_bits(in_bits), .tgt_64(tgt_64), .tgt_signed(tgt_signed),
        .rnd_chop(rnd_chop), .out_valid(out_valid), .out_result(out_result),
        .out_invalid(out_invalid), .out_inexact(out_inexact)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [63:0] b, input logic dbl, input logic t64,
                         input logic sgn, input logic chop);
        in_valid   = 1'b1;
        in_bits    = b;
        in_dbl     = dbl;
        tgt_64     = t64;
        tgt_signed = sgn;
        rnd_chop   = chop;
    endtask

    task automatic conv(input string req, input logic [63:0] b, input logic dbl,
                        input logic t64, input logic sgn, input logic chop,
                        input logic [63:0] exp_res, input logic exp_inv,
                        input logic exp_inx);
        @(negedge clk);
        drive(b, dbl, t64, sgn, chop);
        @(negedge clk);
        in_valid = 1'b0;
        in_bits  = 64'hA5A5_5A5A_A5A5_5A5A;
        @(negedge clk);
        chk(req, "valid",   {63'd0, out_valid},   64'd1);
        chk(req, "result",  out_result,           exp_res);
        chk(req, "invalid", {63'd0, out_invalid}, {63'd0, exp_inv});
        chk(req, "inexact", {63'd0, out_inexact}, {63'd0, exp_inx});
    endtask

    task automatic t_reset;
        // R12: outputs cleared under reset even with an operand presented.
        drive(64'h7FF8_0000_0000_0000, 1'b1, 1'b1, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        chk("R12", "valid in reset",   {63'd0, out_valid},   64'd0);
        chk("R12", "result in reset",  out_result,           64'd0);
        chk("R12", "invalid in reset", {63'd0, out_invalid}, 64'd0);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        repeat (2) @(negedge clk);
        chk("R12", "idle valid", {63'd0, out_valid}, 64'd0);
        chk("R12", "idle flags", {62'd0, out_invalid, out_inexact}, 64'd0);
    endtask

    task automatic t_round_nearest;
        conv("R4", 64'h4020_0000, 0, 0, 1, 0, 64'd2, 0, 1);   // 2.5 -> 2
        conv("R4", 64'h4060_0000, 0, 0, 1, 0, 64'd4, 0, 1);   // 3.5 -> 4
        conv("R4", 64'h4030_0000, 0, 0, 1, 0, 64'd3, 0, 1);   // 2.75 -> 3
        conv("R4", 64'h3F00_0000, 0, 0, 1, 0, 64'd0, 0, 1);   // 0.5 -> 0
        conv("R4", 64'h3FC0_0000, 0, 0, 1, 0, 64'd2, 0, 1);   // 1.5 -> 2
        conv("R4", 64'hC020_0000, 0, 1, 1, 0, 64'hFFFF_FFFF_FFFF_FFFE, 0, 1);
        conv("R4", 64'hBFF8_0000_0000_0000, 1, 0, 1, 0, 64'h0000_0000_FFFF_FFFE, 0, 1);
        conv("R4", 64'h4004_0000_0000_0000, 1, 0, 1, 0, 64'd2, 0, 1);
        conv("R10", 64'h0000_0001, 0, 0, 1, 0, 64'd0, 0, 1);  // denormal
    endtask

    task automatic t_truncate;
        conv("R5", 64'h4060_0000, 0, 0, 1, 1, 64'd3, 0, 1);
        conv("R5", 64'h4030_0000, 0, 0, 1, 1, 64'd2, 0, 1);
        conv("R5", 64'hBFF8_0000_0000_0000, 1, 0, 1, 1, LO32, 0, 1);
        conv("R5", 64'h41EF_FFFF_FFF0_0000, 1, 0, 0, 1, LO32, 0, 1);
    endtask

    task automatic t_unsigned_neg;
        conv("R6", 64'hBE80_0000, 0, 0, 0, 0, 64'd0, 1, 0);   // -0.25
        conv("R6", 64'hB380_0000, 0, 1, 0, 1, 64'd0, 1, 0);   // -2^-24 chop
        conv("R6", 64'hB380_0000, 0, 0, 0, 0, 64'd0, 1, 0);
        conv("R6", 64'hFF80_0000, 0, 0, 0, 0, 64'd0, 1, 0);   // -inf
        conv("R6", 64'hBE10_0000_0000_0000, 1, 1, 0, 0, 64'd0, 1, 0);
    endtask

    task automatic t_nan;
        conv("R7", 64'h7FC0_0000, 0, 0, 1, 0, LO32, 1, 0);
        conv("R7", 64'h7FC0_0000, 0, 1, 1, 1, ONES, 1, 0);
        conv("R7", 64'h7FC0_0000, 0, 0, 0, 0, LO32, 1, 0);
        conv("R7", 64'h7FF8_0000_0000_0000, 1, 1, 0, 1, ONES, 1, 0);
    endtask

    task automatic t_signed_sat;
        conv("R8", 64'h7F80_0000, 0, 0, 1, 0, 64'h7FFF_FFFF, 1, 0);
        conv("R8", 64'hFF80_0000, 0, 0, 1, 0, 64'h8000_0000, 1, 0);
        conv("R8", 64'hFF80_0000, 0, 1, 1, 0, 64'h8000_0000_0000_0000, 1, 0);
        conv("R8", 64'h4F00_0000, 0, 0, 1, 0, 64'h7FFF_FFFF, 1, 0);
        conv("R8", 64'hCF00_0000, 0, 0, 1, 0, 64'h8000_0000, 0, 0);
        conv("R8", 64'h43E0_0000_0000_0000, 1, 1, 1, 0, 64'h7FFF_FFFF_FFFF_FFFF, 1, 0);
        conv("R8", 64'hC3E0_0000_0000_0000, 1, 1, 1, 1, 64'h8000_0000_0000_0000, 0, 0);
    endtask

    task automatic t_unsigned_sat;
        conv("R9", 64'h7F80_0000, 0, 1, 0, 0, ONES, 1, 0);
        conv("R9", 64'h4F80_0000, 0, 0, 0, 0, LO32, 1, 0);     // 2^32
        conv("R9", 64'h4F00_0000, 0, 0, 0, 0, 64'h8000_0000, 0, 0);
        conv("R9", 64'h43F0_0000_0000_0000, 1, 1, 0, 0, ONES, 1, 0);
        conv("R9", 64'h43E0_0000_0000_0000, 1, 1, 0, 0, 64'h8000_0000_0000_0000, 0, 0);
        conv("R9", 64'h41EF_FFFF_FFF0_0000, 1, 0, 0, 0, LO32, 1, 0); // rounds over
        conv("R3", 64'h41F0_0000_0000_0000, 1, 1, 0, 0, 64'h1_0000_0000, 0, 0);
        conv("R3", 64'h41F0_0000_0000_0000, 1, 0, 0, 0, LO32, 1, 0);
    endtask

    task automatic t_zero;
        conv("R11", 64'h8000_0000, 0, 0, 0, 0, 64'd0, 0, 0);
        conv("R11", 64'h8000_0000, 0, 1, 1, 1, 64'd0, 0, 0);
        conv("R11", 64'h8000_0000_0000_0000, 1, 1, 0, 0, 64'd0, 0, 0);
        conv("R11", 64'h0, 1, 0, 1, 0, 64'd0, 0, 0);
    endtask

    task automatic t_format;
        // R2: upper word ignored for a binary32 source.
        conv("R2", 64'hDEAD_BEEF_3F80_0000, 0, 0, 1, 0, 64'd1, 0, 0);
        conv("R2", 64'h7FF8_0000_4020_0000, 0, 1, 1, 1, 64'd2, 0, 1);
        conv("R2", 64'h43B0_0000_0000_0000, 1, 1, 1, 0, 64'h1000_0000_0000_0000, 0, 0);
    endtask

    task automatic t_stream;
        // R1: four conversions on consecutive cycles, outputs two cycles later.
        logic [63:0] sb [4];
        logic [3:0]  sd, s64, ss, sc, ei, ex;
        logic [63:0] er [4];
        sb[0] = 64'h4020_0000;           sd[0] = 0; s64[0] = 0; ss[0] = 1; sc[0] = 0;
        er[0] = 64'd2;                   ei[0] = 0; ex[0] = 1;
        sb[1] = 64'h43E0_0000_0000_0000; sd[1] = 1; s64[1] = 1; ss[1] = 0; sc[1] = 0;
        er[1] = 64'h8000_0000_0000_0000; ei[1] = 0; ex[1] = 0;
        sb[2] = 64'h7FC0_0000;           sd[2] = 0; s64[2] = 1; ss[2] = 1; sc[2] = 0;
        er[2] = ONES;                    ei[2] = 1; ex[2] = 0;
        sb[3] = 64'hBE80_0000;           sd[3] = 0; s64[3] = 0; ss[3] = 0; sc[3] = 1;
        er[3] = 64'd0;                   ei[3] = 1; ex[3] = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                chk("R1", "stream valid",   {63'd0, out_valid},   64'd1);
                chk("R1", "stream result",  out_result,           er[i-2]);
                chk("R1", "stream invalid", {63'd0, out_invalid}, {63'd0, ei[i-2]});
                chk("R1", "stream inexact", {63'd0, out_inexact}, {63'd0, ex[i-2]});
            end
            if (i < 4) drive(sb[i], sd[i], s64[i], ss[i], sc[i]);
            else       in_valid = 1'b0;
        end
        @(negedge clk);
        chk("R1", "stream drained", {63'd0, out_valid}, 64'd0);
    endtask

    initial begin
        t_reset();
        t_round_nearest();
        t_truncate();
        t_unsigned_neg();
        t_nan();
        t_signed_sat();
        t_unsigned_sat();
        t_zero();
        t_format();
        t_stream();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule